// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple host port and one asynchronous 1M x 4 extended-data-out DRAM. A host request carries a 20-bit word address, a 2-bit operation code and 4 bits of write data. The controller splits the address into a row half and a column half, presents them on a shared 10-bit address bus and sequences the row strobe, column strobe, write enable and output enable so that each access runs as a read, an early write or a read-modify-write.

After an access the row stays open. A following request to the same row runs as a page cycle: only the column strobe toggles, and read data stays on the bus after the column strobe rises. A request to another row closes the page, holds the row strobe high for the precharge time and opens the new row. An interval counter raises periodic refresh requests. A pending refresh takes priority over new host work at the next open-page or idle decision point and is issued with the column strobe falling before the row strobe. Every strobe wait is a parameter counted in controller clock cycles.

The host holds `req_i` and its fields steady until it sees a completion strobe. It drops `req_i` on the cycle after the strobe.

Top module: `edo_page_ctrl`

## Requirements
- R1: When the row strobe falls for an access, `dram_addr_o` carries address bits [19:10]. When the column strobe falls, it carries bits [9:0].
- R2: Operation code 01 is a write. Write enable is low one cycle before the column strobe falls. At that fall, output enable is high and `dq_oe_o` is high. Completion is `ack_o` alone, and a later read of the word returns the written data.
- R3: Operation codes 00 and 11 are reads. At the column strobe fall, write enable is high and output enable is low. Completion is `rd_valid_o` alone, with `rd_data_o` equal to the last data written to that word, or 0 if the word was never written.
- R4: Operation code 10 is a read-modify-write. The column strobe stays low while write enable falls, and at that point output enable is high and the data bus is driven. Completion raises `ack_o` and `rd_valid_o` together, with the old data on `rd_data_o`, and the word then holds the new data.
- R5: Consecutive accesses to the open row cause no new row strobe fall.
- R6: Between any rise and the next fall of the row strobe, at least T_RP cycles pass.
- R7: Refresh drives the column strobe low while the row strobe is high, then lowers the row strobe. Consecutive refreshes are never more than REF_INT + 40 cycles apart, and refresh also runs when the host is idle.
- R8: The row strobe is low for at least T_RCD cycles before an access column strobe falls. Every column strobe low pulse lasts at least T_CAS cycles.
- R9: After reset both strobes are high and no completion strobe is raised. `dq_oe_o` is never high while the row strobe is high.
- R10: `ack_o` and `rd_valid_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request, held until completion |
| op_i | input | 2 | 00/11 read, 01 write, 10 read-modify-write |
| addr_i | input | 20 | Word address, row in [19:10], column in [9:0] |
| wdata_i | input | 4 | Write data |
| ack_o | output | 1 | Write or read-modify-write done |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 4 | Read data |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| dram_addr_o | output | 10 | Multiplexed row/column address |
| dq_o | output | 4 | Data to DRAM |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| dq_i | input | 4 | Data from DRAM |

## Verification
A wrong stored row shows up in the access that follows. The bench's DRAM model then latches the wrong row at the strobe fall, so the R1 check fails at that access's completion, and data read back from the wrong word fails within a few operations. A wrong sequencer state or an early timer release shows at once as a shortened strobe pulse or a misordered enable. The strobe checks catch it on the same cycle. A refresh counter that is stuck or runs too slowly shows as a refresh gap over the bound, which is checked once the run ends.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_RMW = 2'd2} op_e;

  typedef enum logic [3:0] {
    S_PRE, S_IDLE, S_ACT, S_OPEN, S_CSET, S_CLOW, S_RMWW, S_RCAS, S_RRAS
  } seq_st_e;

  function automatic op_e decode_op(input logic [1:0] code);
    case (code)
      2'b01:   return OP_WR;
      2'b10:   return OP_RMW;
      default: return OP_RD;
    endcase
  endfunction
endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ROW_W-1:0]  open_row_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              hit_o
);
  assign row_o = addr_i[ADDR_W-1:COL_W];
  assign col_o = addr_i[COL_W-1:0];
  assign hit_o = (row_o == open_row_i);
endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int REF_INT = 780,
  localparam int CW = $clog2(REF_INT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic pend_o
);
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(REF_INT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)        pend_o <= 1'b1;
      else if (take_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/edo_seq_fsm.sv
module edo_seq_fsm import edo_pkg::*; #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DATA_W = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 3,
  localparam int DA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              hit_i,
  input  logic              ref_pend_i,
  output logic              ref_take_o,
  output logic [ROW_W-1:0]  open_row_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [DA_W-1:0]   dram_addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ack_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int REF_LOW = T_RCD + T_CAS;
  localparam int MAXT_A  = (T_RP > REF_LOW) ? T_RP : REF_LOW;
  localparam int TW      = $clog2(MAXT_A + 1);

  seq_st_e           state_q;
  logic [TW-1:0]     tmr_q;
  op_e               op_q, op_in;
  logic [DATA_W-1:0] wdata_q;
  logic              tmr_done;

  assign op_in      = decode_op(op_i);
  assign tmr_done   = (tmr_q == '0);
  assign ref_take_o = (state_q == S_IDLE) && ref_pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_PRE;
      tmr_q       <= TW'(T_RP - 1);
      ras_n_o     <= 1'b1;
      cas_n_o     <= 1'b1;
      we_n_o      <= 1'b1;
      oe_n_o      <= 1'b1;
      dq_oe_o     <= 1'b0;
      dram_addr_o <= '0;
      dq_o        <= '0;
      open_row_o  <= '0;
      op_q        <= OP_RD;
      wdata_q     <= '0;
      ack_o       <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      ack_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      case (state_q)
        S_PRE: begin
          if (tmr_done) state_q <= S_IDLE;
          else          tmr_q   <= tmr_q - 1'b1;
        end
        S_IDLE: begin
          if (ref_pend_i) begin
            cas_n_o <= 1'b0;  // refresh: column strobe leads
            state_q <= S_RCAS;
          end else if (req_i) begin
            ras_n_o     <= 1'b0;
            dram_addr_o <= DA_W'(row_i);
            open_row_o  <= row_i;
            tmr_q       <= TW'(T_RCD - 1);
            state_q     <= S_ACT;
          end
        end
        S_ACT: begin
          if (tmr_done) state_q <= S_OPEN;
          else          tmr_q   <= tmr_q - 1'b1;
        end
        S_OPEN: begin
          if (ref_pend_i || (req_i && !hit_i)) begin
            ras_n_o <= 1'b1;
            oe_n_o  <= 1'b1;
            tmr_q   <= TW'(T_RP - 1);
            state_q <= S_PRE;
          end else if (req_i) begin
            dram_addr_o <= DA_W'(col_i);
            op_q        <= op_in;
            wdata_q     <= wdata_i;
            if (op_in == OP_WR) begin
              we_n_o  <= 1'b0;  // early write: WE before CAS
              oe_n_o  <= 1'b1;
              dq_oe_o <= 1'b1;
              dq_o    <= wdata_i;
            end else begin
              we_n_o  <= 1'b1;
              oe_n_o  <= 1'b0;
              dq_oe_o <= 1'b0;
            end
            state_q <= S_CSET;
          end
        end
        S_CSET: begin
          cas_n_o <= 1'b0;
          tmr_q   <= TW'(T_CAS - 1);
          state_q <= S_CLOW;
        end
        S_CLOW: begin
          if (!tmr_done) begin
            tmr_q <= tmr_q - 1'b1;
          end else if (op_q == OP_RMW) begin
            rd_data_o <= dq_i;
            oe_n_o    <= 1'b1;
            we_n_o    <= 1'b0;
            dq_oe_o   <= 1'b1;
            dq_o      <= wdata_q;
            tmr_q     <= TW'(T_CAS - 1);
            state_q   <= S_RMWW;
          end else begin
            cas_n_o <= 1'b1;
            we_n_o  <= 1'b1;
            dq_oe_o <= 1'b0;
            if (op_q == OP_WR) begin
              ack_o <= 1'b1;
            end else begin
              rd_data_o  <= dq_i;  // OE stays low: data held past CAS rise
              rd_valid_o <= 1'b1;
            end
            state_q <= S_OPEN;
          end
        end
        S_RMWW: begin
          if (!tmr_done) begin
            tmr_q <= tmr_q - 1'b1;
          end else begin
            cas_n_o    <= 1'b1;
            we_n_o     <= 1'b1;
            dq_oe_o    <= 1'b0;
            ack_o      <= 1'b1;
            rd_valid_o <= 1'b1;
            state_q    <= S_OPEN;
          end
        end
        S_RCAS: begin
          ras_n_o <= 1'b0;
          tmr_q   <= TW'(REF_LOW - 1);
          state_q <= S_RRAS;
        end
        S_RRAS: begin
          if (!tmr_done) begin
            tmr_q <= tmr_q - 1'b1;
          end else begin
            ras_n_o <= 1'b1;
            cas_n_o <= 1'b1;
            tmr_q   <= TW'(T_RP - 1);
            state_q <= S_PRE;
          end
        end
        default: state_q <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 10,
  parameter int DATA_W  = 4,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_RP    = 3,
  parameter int REF_INT = 780,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int DA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [DA_W-1:0]   dram_addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  logic [ROW_W-1:0] row, open_row;
  logic [COL_W-1:0] col;
  logic             hit, ref_pend, ref_take;

  edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr_i(addr_i), .open_row_i(open_row),
    .row_o(row), .col_o(col), .hit_o(hit)
  );

  edo_refresh_timer #(.REF_INT(REF_INT)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(ref_take), .pend_o(ref_pend)
  );

  edo_seq_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i),
    .wdata_i(wdata_i), .row_i(row), .col_i(col), .hit_i(hit),
    .ref_pend_i(ref_pend), .ref_take_o(ref_take), .open_row_o(open_row),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .oe_n_o(oe_n_o),
    .dram_addr_o(dram_addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i),
    .ack_o(ack_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o,
  input logic oe_n_o,
  input logic dq_oe_o,
  input logic ack_o,
  input logic rd_valid_o
);
  logic [15:0] ras_hi_cnt, ras_lo_cnt, cas_lo_cnt;

  function automatic logic [15:0] bump(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_hi_cnt <= '0;
      ras_lo_cnt <= '0;
      cas_lo_cnt <= '0;
    end else begin
      ras_hi_cnt <= ras_n_o  ? bump(ras_hi_cnt) : '0;
      ras_lo_cnt <= !ras_n_o ? bump(ras_lo_cnt) : '0;
      cas_lo_cnt <= !cas_n_o ? bump(cas_lo_cnt) : '0;
    end
  end

  assert_early_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !ras_n_o && !we_n_o) |-> (!$past(we_n_o) && oe_n_o && dq_oe_o));

  assert_read_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !ras_n_o && we_n_o) |-> (!oe_n_o && !dq_oe_o));

  assert_rmw_we_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(we_n_o) && !cas_n_o) |-> (oe_n_o && dq_oe_o && !ras_n_o));

  assert_precharge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (ras_hi_cnt >= 16'(T_RP)));

  assert_cbr_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> (!$past(cas_n_o) && !dq_oe_o));

  assert_rcd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !ras_n_o) |-> (ras_lo_cnt >= 16'(T_RCD)));

  assert_cas_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> (cas_lo_cnt >= 16'(T_CAS)));

  assert_standby_hiz_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_n_o |-> !dq_oe_o);

  assert_ack_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_rv_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
  .we_n_o(we_n_o), .oe_n_o(oe_n_o), .dq_oe_o(dq_oe_o),
  .ack_o(ack_o), .rd_valid_o(rd_valid_o)
);

// File: tb/edo_page_ctrl_bench.sv
module edo_page_ctrl_bench;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, REF_INT = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req = 1'b0;
  logic [1:0] op = 2'b00;
  logic [19:0] addr = '0;
  logic [3:0] wdata = '0;
  logic ack, rv, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [3:0] rdata, dq_out, dq_in;
  logic [9:0] da;
  int n_chk = 0, n_bad = 0;

  edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INT(REF_INT)) u_edo_page_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rd_valid_o(rv), .rd_data_o(rdata),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .oe_n_o(oe_n),
    .dram_addr_o(da), .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  // behavioural DRAM and strobe timing monitor
  logic [3:0] dmem [int unsigned];
  logic [3:0] ref_mem [int unsigned];
  logic [9:0] m_row = '0, m_col = '0;
  logic [3:0] m_dout = '0;
  int cyc = 0, act_cnt = 0, ref_cnt = 0, last_ref = 0, max_gap = 0;
  int ras_rise = 0, ras_fall = 0, cas_fall = 0;
  int min_pre = 1000, min_rcd = 1000, min_cas = 1000, hiz_bad = 0;

  always @(posedge clk) cyc++;

  always @(posedge ras_n) ras_rise = cyc;

  always @(negedge ras_n) begin
    if (rst_n && (cyc - ras_rise) < min_pre) min_pre = cyc - ras_rise;
    if (cas_n) begin
      m_row = da; act_cnt++; ras_fall = cyc;
    end else begin
      ref_cnt++;
      if (cyc - last_ref > max_gap) max_gap = cyc - last_ref;
      last_ref = cyc;
    end
  end

  always @(negedge cas_n) begin
    cas_fall = cyc;
    if (!ras_n) begin
      m_col = da;
      if (cyc - ras_fall < min_rcd) min_rcd = cyc - ras_fall;
      if (!we_n) dmem[{12'd0, m_row, m_col}] = dq_out;
      else m_dout = dmem.exists({12'd0, m_row, m_col}) ? dmem[{12'd0, m_row, m_col}] : 4'h0;
    end
  end

  always @(posedge cas_n) if (rst_n && (cyc - cas_fall) < min_cas) min_cas = cyc - cas_fall;

  always @(negedge we_n) if (!cas_n && !ras_n) dmem[{12'd0, m_row, m_col}] = dq_out;

  assign dq_in = (!oe_n && !ras_n && we_n) ? m_dout : 4'h0;

  always @(negedge clk) if (rst_n && ras_n && dq_oe) hiz_bad++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_rd(input logic [19:0] a);
    return ref_mem.exists({12'd0, a}) ? ref_mem[{12'd0, a}] : 4'h0;
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [19:0] a, input logic [3:0] d);
    logic [3:0] exp;
    bit ga, gv;
    int t;
    exp = ref_rd(a);
    @(negedge clk);
    req = 1'b1; op = o; addr = a; wdata = d; t = 0;
    do begin @(negedge clk); t++; end while (!ack && !rv && t < 300);
    ga = ack; gv = rv;
    req = 1'b0;
    chk(t < 300, "R10 completion timeout", t, 300);
    chk(m_row == a[19:10], "R1 row address", int'(m_row), int'(a[19:10]));
    chk(m_col == a[9:0], "R1 column address", int'(m_col), int'(a[9:0]));
    case (o)
      2'b01: begin
        chk(ga && !gv, "R2 write completion", {ga, gv}, 2);
        ref_mem[{12'd0, a}] = d;
      end
      2'b10: begin
        chk(ga && gv, "R4 rmw completion", {ga, gv}, 3);
        chk(rdata == exp, "R4 rmw old data", int'(rdata), int'(exp));
        ref_mem[{12'd0, a}] = d;
      end
      default: begin
        chk(!ga && gv, "R3 read completion", {ga, gv}, 1);
        chk(rdata == exp, "R3 read data", int'(rdata), int'(exp));
      end
    endcase
    @(negedge clk);
    chk(!ack && !rv, "R10 single-cycle strobe", {ack, rv}, 0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int a0, r0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && !dq_oe && !ack && !rv, "R9 reset state",
        {ras_n, cas_n, dq_oe, ack, rv}, 5'b11000);
    rst_n = 1'b1;

    // page hits on one row
    a0 = act_cnt;
    run_op(2'b01, {10'd5, 10'd1}, 4'hA);
    run_op(2'b01, {10'd5, 10'd2}, 4'h3);
    run_op(2'b00, {10'd5, 10'd1}, 4'h0);
    run_op(2'b10, {10'd5, 10'd2}, 4'hC);
    run_op(2'b11, {10'd5, 10'd2}, 4'h0);
    run_op(2'b00, {10'd5, 10'd9}, 4'h0);
    chk(act_cnt - a0 == 1, "R5 page hits one activation", act_cnt - a0, 1);

    // row miss and corner addresses
    run_op(2'b01, {10'd1023, 10'd1023}, 4'hF);
    chk(act_cnt - a0 == 2, "R6 row miss reactivates", act_cnt - a0, 2);
    run_op(2'b01, {10'd0, 10'd0}, 4'h6);
    run_op(2'b00, {10'd1023, 10'd1023}, 4'h0);
    run_op(2'b00, {10'd0, 10'd0}, 4'h0);

    // constrained random traffic
    for (int i = 0; i < 400; i++) begin
      logic [1:0] o;
      o = 2'($urandom % 3);
      run_op(o, {10'($urandom % 4), 10'($urandom % 8)}, 4'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end

    // idle refresh
    r0 = ref_cnt;
    repeat (2 * REF_INT + 50) @(negedge clk);
    chk(ref_cnt - r0 >= 2, "R7 idle refresh", ref_cnt - r0, 2);
    chk(ref_cnt >= cyc / (REF_INT + 40), "R7 refresh count", ref_cnt, cyc / (REF_INT + 40));
    chk(max_gap <= REF_INT + 40, "R7 refresh spacing", max_gap, REF_INT + 40);
    chk(min_pre >= T_RP, "R6 precharge time", min_pre, T_RP);
    chk(min_rcd >= T_RCD, "R8 row to column delay", min_rcd, T_RCD);
    chk(min_cas >= T_CAS, "R8 column pulse width", min_cas, T_CAS);
    chk(hiz_bad == 0, "R9 bus released in standby", hiz_bad, 0);
    summary();
    $finish;
  end
endmodule